// File: doc/BRIEF.md
# IDE PIO Strobe Cycle Timer

This block times one programmed-I/O transfer on a parallel disk bus. A host-side request names a direction (read or write) and one of two drives. The block then holds the address valid for a setup interval and drives the matching read or write strobe for a pulse interval. After the strobe it waits out a recovery interval and raises a one-clock completion pulse.

All three intervals come from per-drive configuration. Each drive has a read timing byte and a write timing byte, and each byte packs a pulse count and a recovery count into two nibbles. A shared miscellaneous byte supplies the drive index used while programming, plus a 2-bit setup count for that drive. Counts are sampled when a cycle starts. A request that arrives while a cycle runs is parked in a single pending slot and starts after the current cycle ends.

Top module: `pio_timing_gen`

## Requirements
- R1: After reset the block is idle with `busy`, `addr_en`, `rd_strobe`, `wr_strobe` and `done` low. Every timing byte resets to 8'hFF, every setup count to 3 and the programming index to 0, so a first request gives setup 4, pulse 16 and recovery 15 clocks.
- R2: A cycle runs in this order: `addr_en` alone for setup+1 clocks, then the strobe with `addr_en` for pulse+1 clocks, then `addr_en` alone for recovery clocks, then `done` high for exactly one clock with `addr_en` low. The two strobes are never high together.
- R3: A read request uses the timing byte at config address 0 and drives `rd_strobe`. A write request uses the byte at address 1 and drives `wr_strobe`. In both bytes, bits 7:4 are the pulse count and bits 3:0 are the recovery count.
- R4: A write to config address 6 sets the programming index from bit 0 and the setup count of that drive from bits 5:4. Bits 7:6 and 3:1 of that byte have no effect on timing.
- R5: A recovery count of 0 makes `done` follow the last strobe clock directly, with no recovery clock.
- R6: Each drive keeps its own read byte, write byte and setup count. Timing writes go to the drive named by the programming index. A request uses the set of `req_drive`, and `cyc_drive` shows that drive during the cycle.
- R7: Timing is captured when a cycle starts. Config writes made during a cycle change only later cycles.
- R8: A request made while a cycle is in progress is kept and runs after the current `done`, with its own direction and drive. `busy` is high from the start of a cycle until the last pending cycle finishes.
- R9: Config writes to addresses other than 0, 1 and 6 change no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config register address |
| cfg_wdata | input | 8 | Config write data |
| req | input | 1 | One-clock transfer request |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_drive | input | 1 | Target drive of the request |
| busy | output | 1 | Cycle running or request pending |
| addr_en | output | 1 | Address valid on the bus |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| done | output | 1 | One-clock end-of-cycle pulse |
| cyc_drive | output | 1 | Drive of the current cycle |

## Verification
The assertions assume that `req` is a single-clock pulse and that no new request arrives while a request is already pending. A request at that point would be lost, and nothing flags it. The bench issues at most one request during a running cycle and none while idle with a slot filled. Config writes are made between cycles, except in the scenario that deliberately rewrites timing in mid-cycle.

// File: rtl/pio_timing_gen.sv
module pio_timing_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       req,
  input  logic       req_write,
  input  logic       req_drive,
  output logic       busy,
  output logic       addr_en,
  output logic       rd_strobe,
  output logic       wr_strobe,
  output logic       done,
  output logic       cyc_drive
);

  localparam logic [2:0] A_RD   = 3'd0;
  localparam logic [2:0] A_WR   = 3'd1;
  localparam logic [2:0] A_MISC = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_RECOV, S_DONE} st_t;

  st_t        st;
  logic [7:0] rd_tim  [2];
  logic [7:0] wr_tim  [2];
  logic [1:0] setup_q [2];
  logic       prog_idx;
  logic       pend_v, pend_wr, pend_drv;
  logic [3:0] cnt, lat_pulse, lat_rec;
  logic       lat_wr, lat_drv;

  wire       start = (st == S_IDLE) && (pend_v || req);
  wire       s_wr  = pend_v ? pend_wr  : req_write;
  wire       s_drv = pend_v ? pend_drv : req_drive;
  wire [7:0] s_tim = s_wr ? wr_tim[s_drv] : rd_tim[s_drv];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        rd_tim[i]  <= 8'hFF;
        wr_tim[i]  <= 8'hFF;
        setup_q[i] <= 2'd3;
      end
      prog_idx <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_RD:   rd_tim[prog_idx] <= cfg_wdata;
        A_WR:   wr_tim[prog_idx] <= cfg_wdata;
        A_MISC: begin
          prog_idx             <= cfg_wdata[0];
          setup_q[cfg_wdata[0]] <= cfg_wdata[5:4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_wr  <= 1'b0;
      pend_drv <= 1'b0;
    end else if (req && st != S_IDLE) begin
      pend_v   <= 1'b1;
      pend_wr  <= req_write;
      pend_drv <= req_drive;
    end else if (start) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lat_pulse <= '0;
      lat_rec   <= '0;
      lat_wr    <= 1'b0;
      lat_drv   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st        <= S_SETUP;
          cnt       <= {2'b00, setup_q[s_drv]};
          lat_pulse <= s_tim[7:4];
          lat_rec   <= s_tim[3:0];
          lat_wr    <= s_wr;
          lat_drv   <= s_drv;
        end
        S_SETUP: if (cnt == 0) begin
          st  <= S_PULSE;
          cnt <= lat_pulse;
        end else cnt <= cnt - 4'd1;
        S_PULSE: if (cnt == 0) begin
          if (lat_rec == 0) st <= S_DONE;
          else begin
            st  <= S_RECOV;
            cnt <= lat_rec - 4'd1;
          end
        end else cnt <= cnt - 4'd1;
        S_RECOV: if (cnt == 0) st <= S_DONE;
                 else cnt <= cnt - 4'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign addr_en   = (st == S_SETUP) || (st == S_PULSE) || (st == S_RECOV);
  assign rd_strobe = (st == S_PULSE) && !lat_wr;
  assign wr_strobe = (st == S_PULSE) && lat_wr;
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE) || pend_v;
  assign cyc_drive = lat_drv;

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  a_r2_strobe_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe || wr_strobe) |-> addr_en);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_en);
  a_r8_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en || done) |-> busy);
  a_r7_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && $past(addr_en)) |-> ($stable(cyc_drive) && $stable(lat_wr)));

endmodule

// File: tb/pio_timing_gen_tb.sv
`timescale 1ns/1ps
module pio_timing_gen_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, req = 0, req_write = 0, req_drive = 0;
  logic [2:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic busy, addr_en, rd_strobe, wr_strobe, done, cyc_drive;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  pio_timing_gen u_dut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .req,
    .req_write, .req_drive, .busy, .addr_en, .rd_strobe, .wr_strobe, .done, .cyc_drive);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send_req(input bit w, input bit drv);
    @(negedge clk); req = 1; req_write = w; req_drive = drv;
    @(negedge clk); req = 0;
  endtask

  task automatic measure(input string tag, input int es, input int ep, input int er,
                         input bit ew, input bit edrv);
    int s = 0, p = 0, r = 0, guard = 0;
    bit bad_dir = 0, bad_drv = 0;
    while (!addr_en && guard < 50) begin @(negedge clk); guard++; end
    while (!done && guard < 200) begin
      if (rd_strobe || wr_strobe) begin
        p++;
        if (wr_strobe != ew || rd_strobe == ew) bad_dir = 1;
        if (cyc_drive != edrv) bad_drv = 1;
      end else if (addr_en && p == 0) s++;
      else if (addr_en) r++;
      @(negedge clk); guard++;
    end
    chk(done, {tag, " done seen"}, done, 1);
    chk(s == es, {tag, " setup clocks"}, s, es);
    chk(p == ep, {tag, " pulse clocks"}, p, ep);
    chk(r == er, {tag, " recovery clocks"}, r, er);
    chk(!bad_dir, {tag, " strobe direction"}, bad_dir, 0);
    chk(!bad_drv, {tag, " drive"}, bad_drv, 0);
    @(negedge clk);
    chk(!done && !addr_en, {tag, " done one clock"}, done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !addr_en && !rd_strobe && !wr_strobe && !done, "R1 idle outputs",
        {busy, addr_en, rd_strobe, wr_strobe, done}, 0);
    send_req(0, 0);
    measure("R1 reset timing", 4, 16, 15, 0, 0);
    chk(!busy, "R1 busy clears", busy, 0);
  endtask

  task automatic t_basic();
    cfg_write(3'd6, 8'h00);
    cfg_write(3'd0, 8'h52);
    cfg_write(3'd1, 8'h31);
    send_req(0, 0); measure("R3 read drive0", 1, 6, 2, 0, 0);
    send_req(1, 0); measure("R3 write drive0", 1, 4, 1, 1, 0);
  endtask

  task automatic t_drives();
    cfg_write(3'd6, 8'h21);
    cfg_write(3'd0, 8'h14);
    send_req(0, 1); measure("R6 read drive1", 3, 2, 4, 0, 1);
    send_req(0, 0); measure("R6 drive0 kept", 1, 6, 2, 0, 0);
  endtask

  task automatic t_misc_ignore();
    cfg_write(3'd6, 8'hCE);
    send_req(0, 0); measure("R4 misc extra bits", 1, 6, 2, 0, 0);
  endtask

  task automatic t_zero_rec();
    cfg_write(3'd0, 8'h30);
    send_req(0, 0); measure("R5 zero recovery", 1, 4, 0, 0, 0);
  endtask

  task automatic t_other_addr();
    cfg_write(3'd5, 8'h00);
    cfg_write(3'd2, 8'h00);
    cfg_write(3'd7, 8'h00);
    send_req(0, 0); measure("R9 other address", 1, 4, 0, 0, 0);
  endtask

  task automatic t_midcycle();
    cfg_write(3'd0, 8'h20);
    send_req(0, 0);
    fork
      measure("R7 in-flight", 1, 3, 0, 0, 0);
      begin
        cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 8'h77;
        @(negedge clk); cfg_we = 0;
      end
    join
    send_req(0, 0); measure("R7 next cycle", 1, 8, 7, 0, 0);
  endtask

  task automatic t_pending();
    bit b;
    send_req(1, 0);
    fork
      begin
        measure("R8 first", 1, 4, 1, 1, 0);
        measure("R8 queued", 3, 2, 4, 0, 1);
      end
      begin
        req = 1; req_write = 0; req_drive = 1;
        @(negedge clk); req = 0;
        b = busy;
        chk(b, "R8 busy while pending", b, 1);
      end
    join
    chk(!busy, "R8 busy clears", busy, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_drives();
    t_misc_ignore();
    t_zero_rec();
    t_other_addr();
    t_midcycle();
    t_pending();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule